// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps a 12-hour wall-clock time as four BCD fields: tenths of a second, seconds, minutes and hours. The hours field carries an AM/PM flag in its top bit. Time advances on a slow external tick pulse of 50 or 60 Hz. A divider turns those ticks into one tenths step every five or every six ticks, chosen by an input.

A small register port writes and reads the four fields by a 2-bit field address. An input decides whether writes land in the running clock or in a parallel set of alarm fields. After every tenths step the clock is compared with the alarm, and a match produces a one-cycle pulse for an interrupt block.

To let software read a multi-field time that stays consistent, a read of hours captures all four fields into a snapshot. Later reads return that snapshot until tenths is read, which releases it. The live clock keeps counting during the hold.

Top module: `tod_clock`

## Requirements
- R1: After reset the clock fields, the alarm fields and the tick divider are all zero, and `alarm_pulse` is low.
- R2: With `rate_short` high the divider gives one tenths step per 5 ticks, and with it low one step per 6 ticks. The rate is sampled when the divider reloads, and the first tick after reset produces a step.
- R3: Writes are masked per field: tenths keeps bits 3:0, seconds and minutes keep bits 6:0, and hours keeps bits 7 and 4:0. Field addresses are 0 for tenths, 1 for seconds, 2 for minutes and 3 for hours. If a clock write and a step fall in the same cycle, the write wins and the step is dropped.
- R4: While `alarm_sel` is high, writes go to the alarm fields and leave the clock unchanged. Reads always return clock fields.
- R5: Tenths count 0 to 9. A step from 9, or from any written value above 9, gives 0 and carries into seconds.
- R6: Seconds and minutes count in BCD from 00 to 59. A step past 59 gives 00 and carries into the next field.
- R7: Hours count in BCD 00 to 11 with the AM/PM flag (bit 7) kept. A step past 11 gives hours 00 with the flag inverted, so 0x11 becomes 0x80 and 0x91 becomes 0x00.
- R8: `alarm_pulse` is high for exactly one cycle when, after a tenths step, all four clock fields equal the four alarm fields. Writes alone never produce a pulse.
- R9: A read of hours captures all four clock fields. Until tenths is read, reads return the captured values while the clock keeps counting. The tenths read returns the captured tenths and ends the hold.
- R10: `rdata` is registered. It shows the selected field in the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse from the 50/60 Hz time base |
| rate_short | input | 1 | 1: five ticks per tenths step, 0: six ticks |
| alarm_sel | input | 1 | 1: writes go to alarm fields, 0: to clock fields |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Field address: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| alarm_pulse | output | 1 | One-cycle alarm match event |

## Verification
Several input patterns are used. All sixteen possible tenths values are stepped, which separates the legal 0 to 9 range from the written values above 9 that must wrap with a carry. Every legal seconds value and every legal minutes value is placed just before a carry. All twelve hours are tried in both halves of the day, which separates a plain BCD increment from the 11-to-00 wrap that inverts the AM/PM flag. Tick runs with both rate settings, alarm writes followed by a countdown to the match, and reads across a hold with steps underneath show the divider period, the write steering and the snapshot release.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    F_TENTHS = 2'd0,
    F_SEC    = 2'd1,
    F_MIN    = 2'd2,
    F_HOUR   = 2'd3
  } tod_field_e;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
    logic [7:0] tn;
  } tod_time_t;

  localparam logic [7:0] MASK_TN = 8'h0F;
  localparam logic [7:0] MASK_SC = 8'h7F;
  localparam logic [7:0] MASK_MN = 8'h7F;
  localparam logic [7:0] MASK_HR = 8'h9F;

  function automatic logic [7:0] field_of(input tod_time_t t, input tod_field_e f);
    case (f)
      F_TENTHS: return t.tn;
      F_SEC:    return t.sc;
      F_MIN:    return t.mn;
      default:  return t.hr;
    endcase
  endfunction

endpackage

// File: rtl/tod_divider.sv
module tod_divider #(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic short_i,
  output logic step_o
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT);
  localparam logic [CW-1:0] RELOAD_S = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] RELOAD_L = CW'(LONG_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q == '0) begin
          step_q <= 1'b1;
          cnt_q  <= short_i ? RELOAD_S : RELOAD_L;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign step_o = step_q;

  // R2: a step never repeats on the next cycle and is always caused by a tick
  p_step_gap_r2: assert property (@(posedge clk) disable iff (rst)
    step_q |=> !step_q);
  p_step_from_tick_r2: assert property (@(posedge clk) disable iff (rst)
    step_q |-> $past(tick_i));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       wr_i,
  input  tod_field_e wr_field_i,
  input  logic [7:0] wdata_i,
  output tod_time_t  time_o,
  output logic       stepped_o
);

  tod_time_t cur_q;
  tod_time_t inc;
  logic      stepped_q;
  logic      c_s, c_m;
  logic [4:0] tn_nxt;

  // Base-60 BCD increment: {carry, next value}
  function automatic logic [8:0] inc_base60(input logic [7:0] v);
    logic [4:0] lo;
    logic [3:0] hi;
    lo = {1'b0, v[3:0]} + 5'd1;
    hi = {1'b0, v[6:4]};
    if (lo > 5'd9) begin
      lo = 5'd0;
      hi = hi + 4'd1;
    end
    if (hi > 4'd5) return {1'b1, 8'h00};
    return {2'b00, hi[2:0], lo[3:0]};
  endfunction

  // 12-hour BCD increment with AM/PM toggle past 11
  function automatic logic [7:0] inc_hour(input logic [7:0] v);
    logic [4:0] lo;
    logic [1:0] hi;
    logic [5:0] hv;
    lo = {1'b0, v[3:0]} + 5'd1;
    hi = {1'b0, v[4]};
    if (lo > 5'd9) begin
      lo = 5'd0;
      hi = hi + 2'd1;
    end
    hv = {hi, lo[3:0]};
    if (hv > 6'h11) return {~v[7], 7'b0};
    return {v[7], 2'b00, hv[4:0]};
  endfunction

  always_comb begin
    inc    = cur_q;
    c_s    = 1'b0;
    c_m    = 1'b0;
    tn_nxt = {1'b0, cur_q.tn[3:0]} + 5'd1;
    if (tn_nxt > 5'd9) begin
      inc.tn = 8'h00;
      {c_s, inc.sc} = inc_base60(cur_q.sc);
      if (c_s) begin
        {c_m, inc.mn} = inc_base60(cur_q.mn);
        if (c_m) inc.hr = inc_hour(cur_q.hr);
      end
    end else begin
      inc.tn = {4'b0, tn_nxt[3:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= '0;
      stepped_q <= 1'b0;
    end else begin
      stepped_q <= step_i && !wr_i;
      if (wr_i) begin
        // a write takes priority; a coincident step is dropped
        case (wr_field_i)
          F_TENTHS: cur_q.tn <= wdata_i & MASK_TN;
          F_SEC:    cur_q.sc <= wdata_i & MASK_SC;
          F_MIN:    cur_q.mn <= wdata_i & MASK_MN;
          default:  cur_q.hr <= wdata_i & MASK_HR;
        endcase
      end else if (step_i) begin
        cur_q <= inc;
      end
    end
  end

  assign time_o    = cur_q;
  assign stepped_o = stepped_q;

  // R3: hour bits 6:5 are never set by a write
  p_hour_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_i && wr_field_i == F_HOUR) |=> (cur_q.hr[6:5] == 2'b00));
  // R5: a step always leaves tenths in range
  p_tenths_range_r5: assert property (@(posedge clk) disable iff (rst)
    (step_i && !wr_i) |=> (cur_q.tn <= 8'h09));
  // R6: seconds roll from 59 to 00 on carry
  p_sec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !wr_i && cur_q.tn == 8'h09 && cur_q.sc == 8'h59) |=> (cur_q.sc == 8'h00));
  // R7: hours wrap past 11 inverts AM/PM
  p_hour_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i && !wr_i && cur_q.tn == 8'h09 && cur_q.sc == 8'h59 &&
     cur_q.mn == 8'h59 && cur_q.hr[4:0] == 5'h11)
    |=> (cur_q.hr == {~$past(cur_q.hr[7]), 7'b0}));

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  tod_field_e wr_field_i,
  input  logic [7:0] wdata_i,
  input  tod_time_t  time_i,
  input  logic       stepped_i,
  output logic       pulse_o
);

  tod_time_t alm_q;
  logic      pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_i) begin
        case (wr_field_i)
          F_TENTHS: alm_q.tn <= wdata_i & MASK_TN;
          F_SEC:    alm_q.sc <= wdata_i & MASK_SC;
          F_MIN:    alm_q.mn <= wdata_i & MASK_MN;
          default:  alm_q.hr <= wdata_i & MASK_HR;
        endcase
      end
      // compare the freshly stepped clock against the alarm
      pulse_q <= stepped_i && (time_i == alm_q);
    end
  end

  assign pulse_o = pulse_q;

  // R8: one-cycle pulse, only after a step
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  p_pulse_after_step_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(stepped_i));

endmodule

// File: rtl/tod_readhold.sv
module tod_readhold
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_i,
  input  tod_field_e rd_field_i,
  input  tod_time_t  time_i,
  output logic [7:0] rdata_o
);

  tod_time_t held_q;
  logic      hold_q;
  logic [7:0] rdata_q;
  tod_time_t visible;

  assign visible = hold_q ? held_q : time_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      hold_q  <= 1'b0;
      rdata_q <= 8'h00;
    end else if (rd_i) begin
      rdata_q <= field_of(visible, rd_field_i);
      if (rd_field_i == F_HOUR && !hold_q) begin
        held_q <= time_i;
        hold_q <= 1'b1;
      end else if (rd_field_i == F_TENTHS) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign rdata_o = rdata_q;

  // R9: a tenths read always ends the hold; an hours read always starts one
  p_hold_release_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rd_field_i == F_TENTHS) |=> !hold_q);
  p_hold_enter_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rd_field_i == F_HOUR) |=> hold_q);
  // R10: read data only moves on a read
  p_rdata_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rate_short,
  input  logic       alarm_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_pulse
);

  tod_field_e field;
  logic       step;
  logic       stepped;
  logic       clk_wr, alm_wr;
  tod_time_t  now;

  assign field  = tod_field_e'(addr);
  assign clk_wr = wr_en && !alarm_sel;
  assign alm_wr = wr_en && alarm_sel;

  tod_divider #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_div (
    .clk(clk), .rst(rst), .tick_i(tick), .short_i(rate_short), .step_o(step)
  );

  tod_counter u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .wr_i(clk_wr), .wr_field_i(field),
    .wdata_i(wdata), .time_o(now), .stepped_o(stepped)
  );

  tod_alarm u_alm (
    .clk(clk), .rst(rst), .wr_i(alm_wr), .wr_field_i(field), .wdata_i(wdata),
    .time_i(now), .stepped_i(stepped), .pulse_o(alarm_pulse)
  );

  tod_readhold u_rd (
    .clk(clk), .rst(rst), .rd_i(rd_en), .rd_field_i(field), .time_i(now),
    .rdata_o(rdata)
  );

  // R4: steered alarm writes leave the clock untouched
  p_alarm_steer_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && alarm_sel && !step) |=> $stable(now));

endmodule

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, rate_short = 1'b1, alarm_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic alarm_pulse;

  int checks = 0, failures = 0, pulses = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tod_clock u_tod_clock (
    .clk(clk), .rst(rst), .tick(tick), .rate_short(rate_short),
    .alarm_sel(alarm_sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alarm_pulse(alarm_pulse)
  );

  always @(negedge clk) if (!rst && alarm_pulse) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  // hours first (captures), tenths last (releases)
  task automatic read_all(output logic [31:0] v);
    logic [7:0] h, m, s, t;
    rd(2'd3, h); rd(2'd2, m); rd(2'd1, s); rd(2'd0, t);
    v = {h, m, s, t};
  endtask

  task automatic set_clock(input logic [31:0] v);
    wr(2'd3, v[31:24]); wr(2'd2, v[23:16]); wr(2'd1, v[15:8]); wr(2'd0, v[7:0]);
  endtask

  task automatic tick_once();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic one_step();
    repeat (5) tick_once();
  endtask

  function automatic logic [7:0] to_bcd(input int d);
    return 8'((d / 10) * 16 + (d % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  // next time after one tenths step, from the requirements
  function automatic logic [31:0] model_step(input logic [31:0] v);
    logic [7:0] h, m, s, t;
    int d;
    {h, m, s, t} = v;
    if (t >= 8'd9) begin
      t = 8'h00;
      d = from_bcd(s) + 1;
      if (d == 60) begin
        s = 8'h00;
        d = from_bcd(m) + 1;
        if (d == 60) begin
          m = 8'h00;
          d = from_bcd({3'b0, h[4:0]}) + 1;
          if (d == 12) h = h[7] ? 8'h00 : 8'h80;
          else h = {h[7], 7'b0} | to_bcd(d);
        end else m = to_bcd(d);
      end else s = to_bcd(d);
    end else t = t + 8'd1;
    return {h, m, s, t};
  endfunction

  initial begin : main
    logic [31:0] got, start;
    logic [7:0] v;
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 alarm_pulse low", {31'b0, alarm_pulse}, 32'd0);
    read_all(got);
    check("R1 clock zero", got, 32'h0);

    // R2 divider
    tick_once();
    read_all(got); check("R2 first tick steps", got, 32'h0000_0001);
    repeat (4) tick_once();
    read_all(got); check("R2 short no step at 4", got, 32'h0000_0001);
    tick_once();
    read_all(got); check("R2 short step at 5", got, 32'h0000_0002);
    rate_short = 1'b0;
    repeat (5) tick_once();
    read_all(got); check("R2 reload step", got, 32'h0000_0003);
    repeat (5) tick_once();
    read_all(got); check("R2 long no step at 5", got, 32'h0000_0003);
    rate_short = 1'b1;
    tick_once();
    read_all(got); check("R2 long step at 6", got, 32'h0000_0004);

    // R3 masks
    set_clock(32'hFFFF_FFFF);
    read_all(got); check("R3 write masks", got, 32'h9F7F_7F0F);

    // R5 tenths sweep including values above 9
    for (int t = 0; t < 16; t++) begin
      start = {24'h0, 8'(t)};
      set_clock(start); one_step(); read_all(got);
      check("R5 tenths step", got, model_step(start));
    end
    // R6 seconds sweep
    for (int s = 0; s < 60; s++) begin
      start = {16'h0, to_bcd(s), 8'h09};
      set_clock(start); one_step(); read_all(got);
      check("R6 seconds step", got, model_step(start));
    end
    // R6 minutes sweep
    for (int m = 0; m < 60; m++) begin
      start = {8'h00, to_bcd(m), 8'h59, 8'h09};
      set_clock(start); one_step(); read_all(got);
      check("R6 minutes step", got, model_step(start));
    end
    // R7 hours sweep, both halves of the day
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 0; h < 12; h++) begin
        start = {(pm != 0 ? 8'h80 : 8'h00) | to_bcd(h), 8'h59, 8'h59, 8'h09};
        set_clock(start); one_step(); read_all(got);
        check("R7 hours step", got, model_step(start));
      end
    end

    // R4 steering and R8 alarm
    set_clock(32'h0102_0304);
    p0 = pulses;
    alarm_sel = 1'b1;
    wr(2'd3, 8'h85); wr(2'd2, 8'h30); wr(2'd1, 8'h15); wr(2'd0, 8'h03);
    alarm_sel = 1'b0;
    read_all(got); check("R4 clock unchanged by alarm write", got, 32'h0102_0304);
    set_clock(32'h8530_1503);
    check("R8 no pulse from writes", pulses - p0, 0);
    wr(2'd0, 8'h01);
    one_step(); read_all(got);
    check("R8 no pulse before match", pulses - p0, 0);
    check("R8 clock before match", got, 32'h8530_1502);
    one_step();
    check("R8 single pulse on match", pulses - p0, 1);
    one_step();
    check("R8 no pulse after match", pulses - p0, 1);

    // R9 read hold
    set_clock(32'h0000_5908);
    rd(2'd3, v); check("R9 hours captured", {24'h0, v}, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", {24'h0, rdata}, 32'h0);
    one_step(); one_step();
    rd(2'd2, v); check("R9 held minutes", {24'h0, v}, 32'h00);
    rd(2'd1, v); check("R9 held seconds", {24'h0, v}, 32'h59);
    rd(2'd0, v); check("R9 held tenths", {24'h0, v}, 32'h08);
    read_all(got); check("R9 counted underneath", got, 32'h0001_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule